// File: doc/BRIEF.md
# Segment Table Address Translator

This unit turns a virtual address into a physical one through a small table of segments held in registers. The top bits of the virtual address pick one of eight segment entries. The remaining bits are an offset inside that segment. Each entry has a start address in physical memory, a size limit and a valid flag.

An offset that lies inside the size limit is added to the entry's start address. Two cases produce a trap with its own fault code instead of an address: an offset at or beyond the limit, and a reference to an entry that is not valid. A separate port lets the controlling software load or replace any entry.

A request is presented for one cycle, and its response appears on the registered outputs one cycle later. The lookup reads the table as it stood before the clock edge. A write therefore becomes visible to lookups only from the following cycle onward.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0 and every table entry is invalid, so a lookup of any segment returns fault code 1.
- R2: The segment number is `req_va[31:29]` and the offset is `req_va[28:0]`.
- R3: When the selected entry is valid and the offset is below its bound, `rsp_pa` equals the entry's base plus the offset, and `rsp_fault` is 0.
- R4: When the selected entry is valid and the offset is greater than or equal to its bound, `rsp_fault` is 2 and `rsp_pa` is 0.
- R5: When the selected entry is invalid, `rsp_fault` is 1 and `rsp_pa` is 0, whatever the offset.
- R6: The response to a request sampled at one rising edge appears, with `rsp_valid` high, right after that edge. In a cycle without a request, the next response has `rsp_valid` 0, `rsp_pa` 0 and `rsp_fault` 0.
- R7: A table write with `wr_en` high is visible to lookups from the next cycle. A lookup of the same entry in the cycle of the write returns the entry's old contents.
- R8: A write to one entry leaves every other entry unchanged.
- R9: The sum of base and offset wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 invalid segment, 2 bounds violation |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_base | input | 32 | New base address |
| wr_bound | input | 30 | New size limit in bytes |
| wr_valid | input | 1 | New valid flag |

## Verification
Each lookup result is due exactly one rising edge after the request is driven. The bench drives inputs on the falling edge, waits for the next rising edge and samples one time unit later. Table writes use the same one-edge delay. The same-cycle case drives a write and a lookup of the same entry together, checks that the old contents come back, and then repeats the lookup one cycle later to confirm the new contents.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int unsigned DEF_VA_W  = 32;
    localparam int unsigned DEF_SEG_W = 3;
    localparam int unsigned DEF_PA_W  = 32;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_BOUNDS  = 2'd2
    } fault_e;

    function automatic fault_e classify(input logic valid, input logic over);
        if (!valid)    return FLT_INVALID;
        else if (over) return FLT_BOUNDS;
        else           return FLT_NONE;
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int unsigned SEG_W = 3,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned BND_W = 30,
    localparam int unsigned SEG_N = 1 << SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [BND_W-1:0] wr_bound,
    input  logic             wr_valid,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [BND_W-1:0] rd_bound,
    output logic             rd_valid
);
    logic [PA_W-1:0]  base_q  [SEG_N];
    logic [BND_W-1:0] bound_q [SEG_N];
    logic             vld_q   [SEG_N];

    for (genvar i = 0; i < SEG_N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i]  <= '0;
                bound_q[i] <= '0;
                vld_q[i]   <= 1'b0;
            end else if (wr_en && wr_idx == SEG_W'(i)) begin
                base_q[i]  <= wr_base;
                bound_q[i] <= wr_bound;
                vld_q[i]   <= wr_valid;
            end
        end
    end

    assign rd_base  = base_q[rd_idx];
    assign rd_bound = bound_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
#(
    parameter int unsigned OFF_W = 29,
    parameter int unsigned PA_W  = 32,
    localparam int unsigned BND_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [PA_W-1:0]  base,
    input  logic [BND_W-1:0] bound,
    input  logic             valid,
    output logic [PA_W-1:0]  pa,
    output fault_e           fault
);
    logic over;

    always_comb begin
        over  = {1'b0, offset} >= bound;
        fault = classify(valid, over);
        if (fault == FLT_NONE) pa = base + PA_W'(offset);
        else                   pa = '0;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int unsigned VA_W  = DEF_VA_W,
    parameter int unsigned SEG_W = DEF_SEG_W,
    parameter int unsigned PA_W  = DEF_PA_W,
    localparam int unsigned OFF_W = VA_W - SEG_W,
    localparam int unsigned BND_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [BND_W-1:0] wr_bound,
    input  logic             wr_valid
);
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
    logic [PA_W-1:0]  ent_base;
    logic [BND_W-1:0] ent_bound;
    logic             ent_valid;
    logic [PA_W-1:0]  pa_c;
    fault_e           fault_c;

    assign seg = req_va[VA_W-1 -: SEG_W];
    assign off = req_va[OFF_W-1:0];

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_bound(wr_bound), .wr_valid(wr_valid),
        .rd_idx(seg), .rd_base(ent_base), .rd_bound(ent_bound), .rd_valid(ent_valid)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_check (
        .offset(off), .base(ent_base), .bound(ent_bound), .valid(ent_valid),
        .pa(pa_c), .fault(fault_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= FLT_NONE;
        end else if (req_valid) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= pa_c;
            rsp_fault <= fault_c;
        end else begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= FLT_NONE;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int unsigned PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic [1:0]      rsp_fault
);
    assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && rsp_pa == '0 && rsp_fault == 2'd0));
    assert_fault_no_pa_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_pa == '0);
    assert_fault_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault != 2'd3);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_base = '0;
    logic [29:0] wr_bound = '0;
    logic        wr_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_xlate dut (.*);

    function automatic logic [31:0] va(input int s, input int o);
        return {s[2:0], o[28:0]};
    endfunction

    task automatic check(input string req, input logic v, input logic [31:0] pa, input logic [1:0] f);
        checks++;
        if (rsp_valid !== v || rsp_pa !== pa || rsp_fault !== f) begin
            errors++;
            $display("FAIL %s: got v=%0b pa=%0d f=%0d, expected v=%0b pa=%0d f=%0d",
                     req, rsp_valid, rsp_pa, rsp_fault, v, pa, f);
        end
    endtask

    task automatic write(input int idx, input logic [31:0] b, input logic [29:0] bd, input logic v);
        @(negedge clk);
        wr_en = 1; wr_idx = idx[2:0]; wr_base = b; wr_bound = bd; wr_valid = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic [31:0] pa, input logic [1:0] f);
        @(negedge clk);
        req_valid = 1; req_va = a;
        @(posedge clk); #1;
        check(req, 1'b1, pa, f);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset();
        @(negedge clk); #0;
        @(posedge clk); #1;
        check("R1 reset idle", 1'b0, 32'd0, 2'd0);
        rst = 0;
        for (int s = 0; s < 8; s++) lookup("R1 invalid after reset", va(s, 5), 32'd0, 2'd1);
    endtask

    task automatic t_load();
        write(0, 1000, 400, 1);
        write(1, 0, 500, 1);
        write(2, 600, 300, 1);
        write(3, 1500, 400, 1);
    endtask

    task automatic t_map();
        lookup("R3 seg0 off0", va(0, 0), 32'd1000, 2'd0);
        lookup("R2 R3 seg2 off40", va(2, 40), 32'd640, 2'd0);
        lookup("R3 seg1 last byte", va(1, 499), 32'd499, 2'd0);
        lookup("R3 seg3 off399", va(3, 399), 32'd1899, 2'd0);
    endtask

    task automatic t_bounds();
        lookup("R4 seg1 at bound", va(1, 500), 32'd0, 2'd2);
        lookup("R4 seg3 at bound", va(3, 400), 32'd0, 2'd2);
        lookup("R4 seg2 far", va(2, 29'h1FFF_FFFF), 32'd0, 2'd2);
    endtask

    task automatic t_invalid();
        lookup("R5 seg5 unloaded", va(5, 0), 32'd0, 2'd1);
        write(2, 600, 300, 0);
        lookup("R5 seg2 cleared", va(2, 10), 32'd0, 2'd1);
        lookup("R8 seg3 untouched", va(3, 10), 32'd1510, 2'd0);
        lookup("R8 seg0 untouched", va(0, 10), 32'd1010, 2'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 0; req_va = va(0, 1);
        @(posedge clk); #1;
        check("R6 no request", 1'b0, 32'd0, 2'd0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1; wr_idx = 3'd4; wr_base = 32'd7000; wr_bound = 30'd50; wr_valid = 1;
        req_valid = 1; req_va = va(4, 20);
        @(posedge clk); #1;
        check("R7 old contents same cycle", 1'b1, 32'd0, 2'd1);
        @(negedge clk);
        wr_en = 0;
        @(posedge clk); #1;
        check("R7 new contents next cycle", 1'b1, 32'd7020, 2'd0);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_wrap();
        write(6, 32'hFFFF_FFF0, 30'h2000_0000, 1);
        lookup("R9 wraps", va(6, 32'h20), 32'h0000_0010, 2'd0);
        lookup("R9 below top", va(6, 32'h5), 32'hFFFF_FFF5, 2'd0);
    endtask

    initial begin
        t_reset();
        t_load();
        t_map();
        t_bounds();
        t_invalid();
        t_idle();
        t_same_cycle();
        t_wrap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule